// File: doc/BRIEF.md
# Serial Flash Register Write-Enable Controller

This block is the device-side command logic of a serial NOR flash, limited to the status and configuration register path. It oversamples chip select, serial clock and serial data input with the system clock. It shifts in commands and data MSB first in SPI mode 0 and keeps two copies each of status register 1 and configuration register 1: a persistent copy and a working (volatile) copy. The working copy is what the device acts on. It is driven out as the active status and configuration, and it can be read back on the serial output.

Two arming commands prepare a register write. The persistent arm (06h) sets the write-enable latch. A register write that follows it updates both copies and starts a busy period of configurable length, which stands in for the real storage write time. The volatile arm (50h) leaves the latch alone and sends the next register write to the working copy only. A fast reconfiguration therefore never touches the persistent copy, and a reset restores the working copy from the persistent one. A program/erase request input is granted only while the latch is set and no write is in progress.

Top module: `spi_regwr_ctrl`

## Requirements
- R1: Opcode 06h, with chip select rising on the boundary straight after its eighth bit, sets the write-enable latch, which is status bit 1.
- R2: An arming opcode (06h or 50h) is discarded when chip select rises after fewer or more than exactly eight bits.
- R3: Opcode 01h, after a persistent arm, writes data byte 1 to status bits 7:2 and data byte 2, if present, to configuration register 1. It writes both the persistent and the working copies. With only one data byte, configuration register 1 keeps its value.
- R4: Opcode 01h, after opcode 50h, writes only the working copies and leaves the write-enable latch unchanged. The persistent copies keep their values, which shows after a reset.
- R5: Reset clears the write-enable latch and the busy bit and reloads both working registers from the persistent ones.
- R6: Opcode 01h is ignored when chip select rises off a byte boundary or before any data byte, and when no arm is pending.
- R7: The volatile arm from 50h is used up by one 01h attempt. Any complete opcode other than 50h, 01h or 05h also cancels it.
- R8: A persistent register write sets the busy bit (status bit 0) for BUSY_CYCLES clocks. When the busy period ends, both the busy bit and the write-enable latch clear.
- R9: While the busy bit is set, every opcode except 05h is ignored.
- R10: Opcode 05h drives the working status register 1 on the serial output, MSB first, changing on SCK falling edges. The byte repeats for as long as chip select stays low.
- R11: pe_grant is high only when pe_req is high, the write-enable latch is set and the busy bit is clear.
- R12: stat_o and cfg_o show the working status register 1 (bit 1 latch, bit 0 busy) and the working configuration register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, mode 0, asynchronous |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device (status readback) |
| pe_req | input | 1 | Program/erase request from the array logic |
| pe_grant | output | 1 | Request accepted under the write-enable rules |
| stat_o | output | 8 | Working status register 1 |
| cfg_o | output | 8 | Working configuration register 1 |

## Verification
The hardest state to reach from the ports is a command that arrives during the busy period of a persistent write. To reach it, the bench makes the busy period longer than three back-to-back transfers. Right after the write it sends a volatile arm and then a two-byte status read. This shows the busy bit at the serial output. After the busy period ends, a register write confirms that the arm sent during the busy period had no effect. The persistent-versus-working split is made visible by issuing a reset after a volatile-only write and checking that the older persistent values return.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  localparam logic [7:0] OP_ARM_PERSIST  = 8'h06;
  localparam logic [7:0] OP_ARM_VOLATILE = 8'h50;
  localparam logic [7:0] OP_REG_WRITE    = 8'h01;
  localparam logic [7:0] OP_STATUS_READ  = 8'h05;
  localparam int         BYTE_W          = 8;
  localparam int         SR_KEEP_W       = 6;   // status bits 7:2 are storable
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              sck_rise,
  input  logic              si,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_vld,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              on_boundary
);
  localparam int              BIT_W   = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst || cs_hi) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (sck_rise) begin
        byte_q <= {byte_q[BYTE_W-2:0], si};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign on_boundary = (bit_cnt == '0);

  // R2: a deselect always restarts framing, so partial bits never carry over
  assert_cs_clears_framing_R2: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (on_boundary && byte_cnt == '0))
    else $error("framing survived deselect");
endmodule

// File: rtl/spi_status_bank.sv
module spi_status_bank #(
  parameter int                 SR_W       = 6,
  parameter int                 CR_W       = 8,
  parameter logic [SR_W-1:0]    NV_SR_INIT = '0,
  parameter logic [CR_W-1:0]    NV_CR_INIT = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_vol,
  input  logic            wr_nv,
  input  logic            wr_cr,
  input  logic [SR_W-1:0] d_sr,
  input  logic [CR_W-1:0] d_cr,
  output logic [SR_W-1:0] v_sr,
  output logic [CR_W-1:0] v_cr
);
  // persistent copies are not touched by reset
  logic [SR_W-1:0] nv_sr = NV_SR_INIT;
  logic [CR_W-1:0] nv_cr = NV_CR_INIT;

  always_ff @(posedge clk) begin
    if (wr_nv) begin
      nv_sr <= d_sr;
      if (wr_cr) nv_cr <= d_cr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sr <= nv_sr;
      v_cr <= nv_cr;
    end else if (wr_nv || wr_vol) begin
      v_sr <= d_sr;
      if (wr_cr) v_cr <= d_cr;
    end
  end

  // R4: a working-only write leaves the persistent copies alone
  assert_vol_write_keeps_nv_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_vol && !wr_nv) |=> ($stable(nv_sr) && $stable(nv_cr)))
    else $error("persistent copy changed by volatile write");

  // R5: leaving reset, the working copies equal the persistent ones
  assert_reset_reload_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (v_sr == nv_sr && v_cr == nv_cr))
    else $error("working copy not reloaded");
endmodule

// File: rtl/spi_regwr_ctrl.sv
module spi_regwr_ctrl
  import spi_regwr_pkg::*;
#(
  parameter int         BUSY_CYCLES = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] NV_SR_INIT  = 8'h00,
  parameter logic [7:0] NV_CR_INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       pe_req,
  output logic       pe_grant,
  output logic [7:0] stat_o,
  output logic [7:0] cfg_o
);
  localparam int CW    = $clog2(BUSY_CYCLES + 1);
  localparam int CNT_W = 3;

  logic [2:0] pins;
  logic       cs_q, sck_q;
  logic       cs_hi, cs_rise, sck_rise, sck_fall;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din({spi_cs_n, spi_sck, spi_mosi}), .dout(pins));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= pins[2];
      sck_q <= pins[1];
    end
  end

  assign cs_hi    = pins[2];
  assign cs_rise  = pins[2] & ~cs_q;
  assign sck_rise = pins[1] & ~sck_q & ~pins[2];
  assign sck_fall = ~pins[1] & sck_q & ~pins[2];

  logic [BYTE_W-1:0] byte_q;
  logic              byte_vld;
  logic [CNT_W-1:0]  byte_cnt;
  logic              on_boundary;

  spi_byte_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .sck_rise(sck_rise), .si(pins[0]),
    .byte_q(byte_q), .byte_vld(byte_vld), .byte_cnt(byte_cnt),
    .on_boundary(on_boundary));

  logic                 wr_en_latch, busy_flag, vol_armed, txn_ok;
  logic [BYTE_W-1:0]    opcode, d_cr;
  logic [SR_KEEP_W-1:0] d_sr;
  logic [CW-1:0]        busy_cnt;
  logic                 rd_active;
  logic [2:0]           rd_bit;
  logic [BYTE_W-1:0]    snap;
  logic [SR_KEEP_W-1:0] v_sr;
  logic [BYTE_W-1:0]    v_cr;
  logic [BYTE_W-1:0]    status;

  // commit decode at the end of a transfer
  logic arm_ok, is_wr, wr_shape_ok, wr_vol, wr_nv, wr_cr;
  assign arm_ok      = cs_rise && txn_ok && on_boundary && byte_cnt == CNT_W'(1);
  assign is_wr       = cs_rise && txn_ok && opcode == OP_REG_WRITE && byte_cnt != '0;
  assign wr_shape_ok = on_boundary && byte_cnt >= CNT_W'(2);
  assign wr_vol      = is_wr && wr_shape_ok && vol_armed;
  assign wr_nv       = is_wr && wr_shape_ok && !vol_armed && wr_en_latch;
  assign wr_cr       = byte_cnt >= CNT_W'(3);

  assign status = {v_sr, wr_en_latch, busy_flag};

  spi_status_bank #(.SR_W(SR_KEEP_W), .CR_W(BYTE_W),
    .NV_SR_INIT(NV_SR_INIT[7:2]), .NV_CR_INIT(NV_CR_INIT)) u_bank (
    .clk(clk), .rst(rst), .wr_vol(wr_vol), .wr_nv(wr_nv), .wr_cr(wr_cr),
    .d_sr(d_sr), .d_cr(d_cr), .v_sr(v_sr), .v_cr(v_cr));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_latch <= 1'b0;
      busy_flag   <= 1'b0;
      vol_armed   <= 1'b0;
      txn_ok      <= 1'b0;
      busy_cnt    <= '0;
      opcode      <= '0;
      rd_active   <= 1'b0;
      rd_bit      <= '0;
      spi_miso    <= 1'b0;
    end else begin
      if (busy_flag) begin
        if (busy_cnt == '0) begin
          busy_flag   <= 1'b0;
          wr_en_latch <= 1'b0;
        end else begin
          busy_cnt <= busy_cnt - 1'b1;
        end
      end

      if (byte_vld) begin
        case (byte_cnt)
          CNT_W'(1): begin
            opcode <= byte_q;
            txn_ok <= !busy_flag;
            if (byte_q == OP_STATUS_READ)
              rd_active <= 1'b1;
            else if (!busy_flag && byte_q != OP_ARM_VOLATILE && byte_q != OP_REG_WRITE)
              vol_armed <= 1'b0;
          end
          CNT_W'(2): d_sr <= byte_q[7:2];
          CNT_W'(3): d_cr <= byte_q;
          default: ;
        endcase
      end

      if (sck_fall && rd_active) begin
        if (rd_bit == '0) begin
          snap     <= status;
          spi_miso <= status[7];
        end else begin
          spi_miso <= snap[3'd7 - rd_bit];
        end
        rd_bit <= rd_bit + 1'b1;
      end

      if (cs_rise) begin
        txn_ok    <= 1'b0;
        rd_active <= 1'b0;
        rd_bit    <= '0;
        spi_miso  <= 1'b0;
        if (arm_ok && opcode == OP_ARM_PERSIST)  wr_en_latch <= 1'b1;
        if (arm_ok && opcode == OP_ARM_VOLATILE) vol_armed   <= 1'b1;
        if (is_wr) vol_armed <= 1'b0;
        if (wr_nv) begin
          busy_flag <= 1'b1;
          busy_cnt  <= CW'(BUSY_CYCLES - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_grant <= 1'b0;
      stat_o   <= '0;
      cfg_o    <= '0;
    end else begin
      pe_grant <= pe_req && wr_en_latch && !busy_flag;
      stat_o   <= status;
      cfg_o    <= v_cr;
    end
  end

  // R1: a well-framed persistent arm leaves the latch set
  assert_arm_sets_latch_R1: assert property (@(posedge clk) disable iff (rst)
    (arm_ok && opcode == OP_ARM_PERSIST) |=> wr_en_latch)
    else $error("persistent arm lost");

  // R8: the end of a busy period always takes the latch down with it
  assert_busy_end_clears_latch_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_flag) |-> !wr_en_latch)
    else $error("latch survived busy end");

  // R9: no working register changes while a persistent write is busy
  assert_busy_freezes_regs_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_flag) && busy_flag) |-> ($stable(v_sr) && $stable(v_cr)))
    else $error("register changed while busy");

  // R4: a working-only write does not move the latch
  assert_vol_write_keeps_latch_R4: assert property (@(posedge clk) disable iff (rst)
    wr_vol |=> (wr_en_latch == $past(wr_en_latch)))
    else $error("volatile write moved latch");

  // R11: a grant is only issued while the latch was set
  assert_grant_needs_latch_R11: assert property (@(posedge clk) disable iff (rst)
    pe_grant |-> $past(wr_en_latch))
    else $error("grant without latch");
endmodule

// File: tb/spi_regwr_ctrl_tb.sv
module spi_regwr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;      // SCK half period in system clocks
  localparam int BUSY       = 500;
  localparam int SETTLE     = 600;
  localparam int NVEC       = 11;

  typedef struct packed {
    logic [7:0]  nbits;
    logic [23:0] data;
    logic [7:0]  stat;
    logic [7:0]  cfg;
  } vec_t;

  // walked from reset state with persistent registers 00/00
  localparam vec_t VEC [NVEC] = '{
    '{8'd8,  24'h060000, 8'h02, 8'h00},  // R1 persistent arm
    '{8'd24, 24'h01AC5A, 8'hAC, 8'h5A},  // R3 R8 persistent write, latch clears
    '{8'd8,  24'h500000, 8'hAC, 8'h5A},  // R4 volatile arm
    '{8'd16, 24'h013000, 8'h30, 8'h5A},  // R4 R3 working-only one byte
    '{8'd24, 24'h01FF11, 8'h30, 8'h5A},  // R6 unarmed write ignored
    '{8'd8,  24'h500000, 8'h30, 8'h5A},  // R7 arm ...
    '{8'd8,  24'h040000, 8'h30, 8'h5A},  // R7 ... cancelled by other opcode
    '{8'd24, 24'h014477, 8'h30, 8'h5A},  // R7 write ignored
    '{8'd8,  24'h500000, 8'h30, 8'h5A},  // R4
    '{8'd24, 24'h014777, 8'h44, 8'h77},  // R4 R12 working write, bits 1:0 not stored
    '{8'd16, 24'h018800, 8'h44, 8'h77}   // R7 arm used up
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, pe_req = 1'b0;
  logic spi_miso, pe_grant;
  logic [7:0] stat_o, cfg_o;
  logic [31:0] rx;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regwr_ctrl #(.BUSY_CYCLES(BUSY), .NV_SR_INIT(8'h00), .NV_CR_INIT(8'h00)) dut_i (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .pe_req(pe_req),
    .pe_grant(pe_grant), .stat_o(stat_o), .cfg_o(cfg_o));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] data, input int n);
    @(negedge clk);
    spi_cs_n = 1'b0;
    spi_mosi = data[31];
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = data[31-i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      rx = {rx[30:0], spi_miso};
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(stat_o, 8'h00, "R5 reset status");
    chk(cfg_o,  8'h00, "R5 reset config");

    for (int i = 0; i < NVEC; i++) begin
      xfer({VEC[i].data, 8'h00}, int'(VEC[i].nbits));
      repeat (SETTLE) @(negedge clk);
      chk(stat_o, VEC[i].stat, $sformatf("R12 vector %0d status", i));
      chk(cfg_o,  VEC[i].cfg,  $sformatf("R12 vector %0d config", i));
    end

    // R5: reset reloads persistent AC/5A over working 44/77
    do_reset();
    chk(stat_o, 8'hAC, "R5 reload status");
    chk(cfg_o,  8'h5A, "R5 reload config");

    // R2: mis-framed arms are discarded
    xfer(32'h06000000, 7);
    chk(stat_o, 8'hAC, "R2 arm with 7 bits");
    xfer(32'h06000000, 9);
    chk(stat_o, 8'hAC, "R2 arm with 9 bits");
    xfer(32'h50000000, 9);
    xfer(32'h01080000, 16);
    chk(stat_o, 8'hAC, "R2 volatile arm with 9 bits");

    // R11 / R1
    pe_req = 1'b1;
    repeat (6) @(negedge clk);
    chk(pe_grant, 1'b0, "R11 no grant without latch");
    xfer(32'h06000000, 8);
    chk(stat_o, 8'hAE, "R1 latch set");
    chk(pe_grant, 1'b1, "R11 grant with latch");

    // R6: bad register-write framing
    xfer(32'h01300000, 12);
    chk(stat_o, 8'hAE, "R6 write off boundary");
    xfer(32'h01000000, 8);
    chk(stat_o, 8'hAE, "R6 write with no data");

    // R8 / R9 / R10: persistent one-byte write, commands during busy
    xfer(32'h01100000, 16);
    chk(stat_o, 8'h13, "R8 busy bit set");
    chk(pe_grant, 1'b0, "R11 no grant while busy");
    xfer(32'h50000000, 8);
    xfer(32'h05000000, 24);
    chk(rx[15:0], 16'h1313, "R10 status read while busy");
    repeat (SETTLE) @(negedge clk);
    chk(stat_o, 8'h10, "R8 busy and latch cleared");
    chk(cfg_o,  8'h5A, "R3 one-byte write keeps config");
    xfer(32'h01000000, 16);
    chk(stat_o, 8'h10, "R9 arm during busy ignored");

    xfer(32'h05000000, 24);
    chk(rx[15:0], 16'h1010, "R10 status read repeats");

    // R4: working-only write keeps latch, persistent copy restored by reset
    xfer(32'h06000000, 8);
    xfer(32'h50000000, 8);
    xfer(32'h01200000, 16);
    chk(stat_o, 8'h22, "R4 working write keeps latch");
    chk(cfg_o,  8'h5A, "R4 config untouched");
    do_reset();
    chk(stat_o, 8'h10, "R4 persistent status unchanged");
    chk(cfg_o,  8'h5A, "R4 persistent config unchanged");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule